// File: doc/BRIEF.md
# Halt/Wait Synchronization Sequencer

This block is the control sequencer a small processor core uses for its instructions that synchronize with outside hardware. Each time it allows a fetch, it takes a decoded instruction class and an optional bus-lock prefix. It then either idles, hands a code to an attached coprocessor, counts out a fixed-length no-operation, or waits for the datapath to finish an ordinary instruction. In every case it reports completion with a one-cycle done pulse.

Two idle states exist. The halted state can be left only by an interrupt or by reset. The wait state ends only when the active-low test input, taken through a synchronizer, goes low. An interrupt taken during the wait state is serviced, and when the service routine returns, the block goes back into the wait state. The interrupt request is held until the surrounding interrupt logic acknowledges it. A saved return target tells the return handshake whether to resume running or waiting. While a prefixed instruction executes, a bus-lock output keeps other masters off the shared bus.

Top module: `sync_seq`

## Requirements
- R1: A synchronous `rst` high at a rising edge puts the block in the running state with `bus_lock` and `int_req` low, from any state including halted, waiting or mid-instruction.
- R2: An instruction is accepted at a rising edge where `fetch_en` and `instr_valid` are both high. `fetch_en` is high only in the running state when no interrupt is being taken. Class codes are 0 ordinary, 1 halt, 2 wait, 3 escape and 4 no-operation; codes 5 to 7 behave as ordinary. An ordinary instruction completes in the cycle `exec_done` is high.
- R3: After a halt is accepted, `fetch_en` stays low and `test_n` has no effect until an interrupt is taken or reset occurs.
- R4: After a wait is accepted, the block idles. It pulses `instr_done` and resumes running in the cycle where the value of `test_n` sampled two rising edges earlier is low.
- R5: An interrupt taken in the wait state raises `ret_to_wait` with `int_req`. After `iret`, the block is back in the wait state with `fetch_en` low.
- R6: NMI takes precedence over INTR, and `int_nmi` reports the source alongside `int_req`. INTR counts only while `int_en` is high; NMI counts regardless.
- R7: `int_req` stays high until `int_ack`. The block then waits for `iret` and resumes running when the interrupt came from the running or halted state.
- R8: An accepted escape raises `esc_strobe` for exactly one cycle with the 6-bit code on `esc_code_out` (zero otherwise). Without a memory operand it completes in that cycle. With one, `esc_mem_req` stays high until `mem_ack`, which completes it.
- R9: A no-operation takes exactly three cycles counted from its acceptance cycle, with `instr_done` high in the third.
- R10: With `lock_pfx` on an ordinary, escape or no-operation instruction, `bus_lock` is high from the first cycle after acceptance through the done cycle and low in the cycle after it. The prefix is ignored for halt and wait, and `bus_lock` is never high while halted or waiting.
- R11: `flag_we` is high only in the done cycle of an ordinary instruction. It is never high for halt, wait, escape or no-operation.
- R12: When the synchronized test condition and a valid interrupt coincide in the wait state, the wait ends (done pulse, no `int_req`). The interrupt is then taken from the running state with `ret_to_wait` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, top priority |
| instr_valid | input | 1 | Decoded instruction is presented |
| instr_class | input | 3 | Instruction class code |
| lock_pfx | input | 1 | Instruction carries the bus-lock prefix |
| esc_code | input | 6 | Coprocessor code of an escape instruction |
| esc_mem | input | 1 | Escape needs one memory operand access |
| exec_done | input | 1 | Datapath finished the ordinary instruction |
| mem_ack | input | 1 | Memory access for the coprocessor finished |
| nmi | input | 1 | Non-maskable interrupt request |
| intr | input | 1 | Maskable interrupt request |
| int_en | input | 1 | Maskable interrupts enabled |
| test_n | input | 1 | Asynchronous test input, active low |
| int_ack | input | 1 | Interrupt logic accepted the request |
| iret | input | 1 | Service routine returned |
| fetch_en | output | 1 | Next instruction may be fetched and accepted |
| int_req | output | 1 | Interrupt service request, held until acknowledged |
| int_nmi | output | 1 | Request is for NMI |
| ret_to_wait | output | 1 | Service return goes back to the wait state |
| bus_lock | output | 1 | Shared bus held for the current instruction |
| esc_strobe | output | 1 | Coprocessor code valid |
| esc_code_out | output | 6 | Coprocessor code |
| esc_mem_req | output | 1 | Memory operand access requested for the coprocessor |
| instr_done | output | 1 | Instruction completion pulse |
| flag_we | output | 1 | Status flag write enable |

## Verification
The cycle that matters most is the one in which the synchronized test condition ends a wait while a valid interrupt is also present. The bench provokes it by lowering `test_n` and raising INTR exactly two edges later. It then expects the done pulse without a request in that cycle, followed by a request from the running state whose return target is not the wait state. Reset is also made to coincide with halt, wait and a locked instruction in progress, and each time the bench expects the running state and a released bus lock on the next cycle. A behavioural model tracks every output on every cycle.

// File: rtl/sync_seq_pkg.sv
package sync_seq_pkg;

   typedef enum logic [2:0] {
      IC_NORMAL = 3'd0,
      IC_HALT   = 3'd1,
      IC_WAIT   = 3'd2,
      IC_ESC    = 3'd3,
      IC_NOP    = 3'd4
   } icls_e;

   typedef enum logic [3:0] {
      ST_RUN,
      ST_EXEC,
      ST_NOP,
      ST_ESC,
      ST_ESCMEM,
      ST_HALT,
      ST_WAIT,
      ST_IREQ,
      ST_ISR
   } seq_st_e;

endpackage

// File: rtl/sync_seq_sync.sv
module sync_seq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sync_seq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) ff[0] <= RST_VAL;
            else     ff[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) ff[i] <= RST_VAL;
            else     ff[i] <= ff[i-1];
         end
      end
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/sync_seq_cnt.sv
module sync_seq_cnt #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic en,
   output logic last
);
   if (LIMIT < 2) begin : g_bad_limit
      $error("sync_seq_cnt: LIMIT must be at least 2");
   end

   localparam int W = $clog2(LIMIT);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || clear)  cnt <= '0;
      else if (en && !last) cnt <= cnt + 1'b1;
   end

   assign last = (cnt == W'(LIMIT-1));
endmodule

// File: rtl/sync_seq_lock.sv
module sync_seq_lock (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic lock
);
   always_ff @(posedge clk) begin
      if (rst)      lock <= 1'b0;
      else if (clr) lock <= 1'b0;
      else if (set) lock <= 1'b1;
   end
endmodule

// File: rtl/sync_seq.sv
module sync_seq
   import sync_seq_pkg::*;
#(
   parameter int CODE_W      = 6,
   parameter int NOP_CYCLES  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              instr_valid,
   input  logic [2:0]        instr_class,
   input  logic              lock_pfx,
   input  logic [CODE_W-1:0] esc_code,
   input  logic              esc_mem,
   input  logic              exec_done,
   input  logic              mem_ack,
   input  logic              nmi,
   input  logic              intr,
   input  logic              int_en,
   input  logic              test_n,
   input  logic              int_ack,
   input  logic              iret,
   output logic              fetch_en,
   output logic              int_req,
   output logic              int_nmi,
   output logic              ret_to_wait,
   output logic              bus_lock,
   output logic              esc_strobe,
   output logic [CODE_W-1:0] esc_code_out,
   output logic              esc_mem_req,
   output logic              instr_done,
   output logic              flag_we
);
   if (NOP_CYCLES < 3) begin : g_bad_nop
      $error("sync_seq: NOP_CYCLES must be at least 3");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("sync_seq: CODE_W must be positive");
   end

   localparam int NOP_WAIT = NOP_CYCLES - 1;

   seq_st_e           st;
   logic [CODE_W-1:0] code_q;
   logic              escmem_q;
   logic              ret_q;
   logic              nmi_q;
   logic              test_s;
   logic              nop_last;
   logic              irq_any;
   logic              accept;
   logic              lock_set;
   icls_e             cls;

   sync_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_test_sync (
      .clk (clk), .rst (rst), .d (test_n), .q (test_s)
   );

   sync_seq_cnt #(.LIMIT(NOP_WAIT)) u_nop_cnt (
      .clk (clk), .rst (rst), .clear (accept),
      .en (st == ST_NOP), .last (nop_last)
   );

   sync_seq_lock u_lock (
      .clk (clk), .rst (rst), .set (lock_set), .clr (instr_done),
      .lock (bus_lock)
   );

   assign cls      = icls_e'(instr_class);
   assign irq_any  = nmi || (intr && int_en);
   assign fetch_en = (st == ST_RUN) && !irq_any;
   assign accept   = fetch_en && instr_valid;
   assign lock_set = accept && lock_pfx && (cls != IC_HALT) && (cls != IC_WAIT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_RUN;
         ret_q    <= 1'b0;
         nmi_q    <= 1'b0;
         code_q   <= '0;
         escmem_q <= 1'b0;
      end else begin
         unique case (st)
            ST_RUN: begin
               if (irq_any) begin
                  st    <= ST_IREQ;
                  ret_q <= 1'b0;
                  nmi_q <= nmi;
               end else if (accept) begin
                  case (cls)
                     IC_HALT: st <= ST_HALT;
                     IC_WAIT: st <= ST_WAIT;
                     IC_NOP:  st <= ST_NOP;
                     IC_ESC: begin
                        st       <= ST_ESC;
                        code_q   <= esc_code;
                        escmem_q <= esc_mem;
                     end
                     default: st <= ST_EXEC;
                  endcase
               end
            end
            ST_EXEC:   if (exec_done) st <= ST_RUN;
            ST_NOP:    if (nop_last)  st <= ST_RUN;
            ST_ESC:    st <= escmem_q ? ST_ESCMEM : ST_RUN;
            ST_ESCMEM: if (mem_ack)   st <= ST_RUN;
            ST_HALT: begin
               if (irq_any) begin
                  st    <= ST_IREQ;
                  ret_q <= 1'b0;
                  nmi_q <= nmi;
               end
            end
            ST_WAIT: begin
               if (!test_s) begin
                  st <= ST_RUN;
               end else if (irq_any) begin
                  st    <= ST_IREQ;
                  ret_q <= 1'b1;
                  nmi_q <= nmi;
               end
            end
            ST_IREQ:   if (int_ack) st <= ST_ISR;
            ST_ISR:    if (iret)    st <= ret_q ? ST_WAIT : ST_RUN;
            default:   st <= ST_RUN;
         endcase
      end
   end

   assign int_req      = (st == ST_IREQ);
   assign int_nmi      = int_req && nmi_q;
   assign ret_to_wait  = ret_q && ((st == ST_IREQ) || (st == ST_ISR));
   assign esc_strobe   = (st == ST_ESC);
   assign esc_code_out = esc_strobe ? code_q : '0;
   assign esc_mem_req  = (st == ST_ESCMEM);
   assign flag_we      = (st == ST_EXEC) && exec_done;
   assign instr_done   = flag_we
                       || ((st == ST_NOP) && nop_last)
                       || ((st == ST_ESC) && !escmem_q)
                       || ((st == ST_ESCMEM) && mem_ack)
                       || ((st == ST_WAIT) && !test_s);

   // R1: reset forces the running state and drops lock and request
   a_r1_reset_run: assert property (@(posedge clk)
      rst |=> (st == ST_RUN && !bus_lock && !int_req));

   // R3: halt persists while no interrupt is valid
   a_r3_halt_stays: assert property (@(posedge clk) disable iff (rst)
      (st == ST_HALT && !nmi && !(intr && int_en)) |=> (st == ST_HALT && !fetch_en));

   // R5: return from service taken in wait goes back to wait
   a_r5_back_to_wait: assert property (@(posedge clk) disable iff (rst)
      (st == ST_ISR && iret && ret_to_wait) |=> (st == ST_WAIT));

   // R7: request held until acknowledged
   a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
      (int_req && !int_ack) |=> int_req);

   // R8: coprocessor strobe lasts one cycle
   a_r8_strobe_once: assert property (@(posedge clk) disable iff (rst)
      esc_strobe |=> !esc_strobe);

   // R9: no completion in the cycle after a no-operation is accepted
   a_r9_nop_gap: assert property (@(posedge clk) disable iff (rst)
      (accept && cls == IC_NOP) |=> !instr_done);

   // R10: lock never held while idle, released after completion
   a_r10_no_lock_idle: assert property (@(posedge clk) disable iff (rst)
      (st == ST_HALT || st == ST_WAIT) |-> !bus_lock);
   a_r10_release: assert property (@(posedge clk) disable iff (rst)
      instr_done |=> !bus_lock);

   // R11: flag write only accompanies a completion
   a_r11_flag_done: assert property (@(posedge clk) disable iff (rst)
      flag_we |-> (instr_done && !esc_strobe && !esc_mem_req));
endmodule

// File: tb/sync_seq_tb_top.sv
`timescale 1ns/1ps
module sync_seq_tb_top;
   localparam int M_RUN = 0, M_EXEC = 1, M_NOP = 2, M_ESC = 3, M_ESCMEM = 4,
                  M_HALT = 5, M_WAIT = 6, M_IREQ = 7, M_ISR = 8;
   localparam int NOPC = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       instr_valid = 1'b0;
   logic [2:0] instr_class = 3'd0;
   logic       lock_pfx = 1'b0;
   logic [5:0] esc_code = 6'd0;
   logic       esc_mem = 1'b0;
   logic       exec_done = 1'b0;
   logic       mem_ack = 1'b0;
   logic       nmi = 1'b0;
   logic       intr = 1'b0;
   logic       int_en = 1'b0;
   logic       test_n = 1'b1;
   logic       int_ack = 1'b0;
   logic       iret = 1'b0;
   logic       fetch_en, int_req, int_nmi, ret_to_wait, bus_lock;
   logic       esc_strobe, esc_mem_req, instr_done, flag_we;
   logic [5:0] esc_code_out;

   always #2 clk = ~clk;

   sync_seq dut_i (
      .clk, .rst, .instr_valid, .instr_class, .lock_pfx, .esc_code, .esc_mem,
      .exec_done, .mem_ack, .nmi, .intr, .int_en, .test_n, .int_ack, .iret,
      .fetch_en, .int_req, .int_nmi, .ret_to_wait, .bus_lock, .esc_strobe,
      .esc_code_out, .esc_mem_req, .instr_done, .flag_we
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit wd_hit = 0;
   bit run_end = 0;

   // behavioural reference state
   int  m_mode = M_RUN;
   int  m_nop = 0;
   int  m_code = 0;
   bit  m_lock = 0, m_retw = 0, m_nmi = 0, m_escmem = 0, mvalid = 0;
   int  tq[$];
   bit  e_ts, e_take, e_fetch, e_done, e_fwe;

   function automatic void calc();
      bit irq;
      e_ts    = (tq.size() >= 2) ? (tq[0] != 0) : 1'b1;
      irq     = nmi || (intr && int_en);
      e_take  = irq && (m_mode == M_RUN || m_mode == M_HALT || (m_mode == M_WAIT && e_ts));
      e_fetch = (m_mode == M_RUN) && !irq;
      e_fwe   = (m_mode == M_EXEC) && exec_done;
      e_done  = e_fwe || (m_mode == M_NOP && m_nop == 1) || (m_mode == M_ESC && !m_escmem)
             || (m_mode == M_ESCMEM && mem_ack) || (m_mode == M_WAIT && !e_ts);
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_mode = M_RUN; m_lock = 0; m_retw = 0; m_nmi = 0; m_escmem = 0;
         m_nop = 0; tq.delete(); mvalid = 1;
      end else if (mvalid) begin
         calc();
         if (e_done) m_lock = 0;
         case (m_mode)
            M_RUN: begin
               if (e_take) begin
                  m_mode = M_IREQ; m_retw = 0; m_nmi = nmi;
               end else if (e_fetch && instr_valid) begin
                  if (lock_pfx && instr_class != 3'd1 && instr_class != 3'd2) m_lock = 1;
                  case (instr_class)
                     3'd1: m_mode = M_HALT;
                     3'd2: m_mode = M_WAIT;
                     3'd3: begin m_mode = M_ESC; m_code = int'(esc_code); m_escmem = esc_mem; end
                     3'd4: begin m_mode = M_NOP; m_nop = NOPC - 1; end
                     default: m_mode = M_EXEC;
                  endcase
               end
            end
            M_EXEC:   if (exec_done) m_mode = M_RUN;
            M_NOP:    if (m_nop == 1) m_mode = M_RUN; else m_nop--;
            M_ESC:    m_mode = m_escmem ? M_ESCMEM : M_RUN;
            M_ESCMEM: if (mem_ack) m_mode = M_RUN;
            M_HALT:   if (e_take) begin m_mode = M_IREQ; m_retw = 0; m_nmi = nmi; end
            M_WAIT: begin
               if (!e_ts) m_mode = M_RUN;
               else if (e_take) begin m_mode = M_IREQ; m_retw = 1; m_nmi = nmi; end
            end
            M_IREQ:   if (int_ack) m_mode = M_ISR;
            M_ISR:    if (iret) m_mode = m_retw ? M_WAIT : M_RUN;
            default:  m_mode = M_RUN;
         endcase
         tq.push_back(int'(test_n));
         if (tq.size() > 2) void'(tq.pop_front());
      end
      if (cycles > 20000 && !wd_hit) begin
         wd_hit = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: all requirements, actual cycles %0d expected under %0d", cycles, 20000);
      end
   end

   task automatic cmp(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      #1;
      if (mvalid && !wd_hit && !run_end) begin
         calc();
         cmp("R2 fetch_en", int'(fetch_en), int'(e_fetch));
         cmp("R7 int_req", int'(int_req), int'(m_mode == M_IREQ));
         cmp("R6 int_nmi", int'(int_nmi), int'(m_mode == M_IREQ && m_nmi));
         cmp("R5 ret_to_wait", int'(ret_to_wait), int'(m_retw && (m_mode == M_IREQ || m_mode == M_ISR)));
         cmp("R10 bus_lock", int'(bus_lock), int'(m_lock));
         cmp("R8 esc_strobe", int'(esc_strobe), int'(m_mode == M_ESC));
         cmp("R8 esc_code_out", int'(esc_code_out), (m_mode == M_ESC) ? m_code : 0);
         cmp("R8 esc_mem_req", int'(esc_mem_req), int'(m_mode == M_ESCMEM));
         cmp("R9 R4 instr_done", int'(instr_done), int'(e_done));
         cmp("R11 flag_we", int'(flag_we), int'(e_fwe));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // present an instruction until accepted; returns at the negedge after acceptance
   task automatic issue(input logic [2:0] c, input logic lk, input logic [5:0] code, input logic mem);
      @(negedge clk);
      instr_valid = 1; instr_class = c; lock_pfx = lk; esc_code = code; esc_mem = mem;
      #1;
      while (!fetch_en && !wd_hit) begin @(negedge clk); #1; end
      @(negedge clk);
      instr_valid = 0; lock_pfx = 0; esc_mem = 0; esc_code = 0; instr_class = 0;
   endtask

   task automatic service();
      int_ack = 1; @(negedge clk); int_ack = 0;
      cyc(1);
      iret = 1; @(negedge clk); iret = 0;
   endtask

   initial begin
      cyc(2);
      rst = 0;
      #1 cmp("R1 fetch_en after reset", int'(fetch_en), 1);
      cmp("R1 bus_lock after reset", int'(bus_lock), 0);

      // R2 R10 R11: locked ordinary instruction
      issue(3'd0, 1, 6'd0, 0);
      #1 cmp("R10 lock in first execute cycle", int'(bus_lock), 1);
      cmp("R2 no fetch while executing", int'(fetch_en), 0);
      @(negedge clk); exec_done = 1;
      #1 cmp("R11 flag_we on ordinary done", int'(flag_we), 1);
      cmp("R10 lock held in done cycle", int'(bus_lock), 1);
      @(negedge clk); exec_done = 0;
      #1 cmp("R10 lock released after done", int'(bus_lock), 0);

      // R2: class 5 behaves as ordinary
      issue(3'd5, 0, 6'd0, 0);
      exec_done = 1;
      #1 cmp("R2 class 5 completes as ordinary", int'(flag_we), 1);
      @(negedge clk); exec_done = 0;

      // R9 R10 R11: locked no-operation
      issue(3'd4, 1, 6'd0, 0);
      #1 cmp("R9 no done in second cycle", int'(instr_done), 0);
      @(negedge clk);
      #1 cmp("R9 done in third cycle", int'(instr_done), 1);
      cmp("R11 no flag write for no-operation", int'(flag_we), 0);
      cmp("R10 lock during no-operation", int'(bus_lock), 1);
      @(negedge clk);
      #1 cmp("R9 running after no-operation", int'(fetch_en), 1);

      // R8: escape without and with memory operand
      issue(3'd3, 0, 6'h2A, 0);
      #1 cmp("R8 code presented", int'(esc_code_out), 'h2A);
      cmp("R8 done without operand", int'(instr_done), 1);
      @(negedge clk);
      #1 cmp("R8 strobe one cycle", int'(esc_strobe), 0);
      issue(3'd3, 1, 6'h15, 1);
      #1 cmp("R8 no done before operand", int'(instr_done), 0);
      @(negedge clk);
      #1 cmp("R8 memory request", int'(esc_mem_req), 1);
      @(negedge clk); mem_ack = 1;
      #1 cmp("R8 done on mem_ack", int'(instr_done), 1);
      @(negedge clk); mem_ack = 0;

      // R3 R6 R7 R10: halt
      issue(3'd1, 1, 6'd0, 0);
      #1 cmp("R10 prefix ignored for halt", int'(bus_lock), 0);
      test_n = 0; cyc(4);
      #1 cmp("R3 test_n ignored in halt", int'(fetch_en), 0);
      test_n = 1; intr = 1; int_en = 0; cyc(2);
      #1 cmp("R6 masked intr ignored", int'(int_req), 0);
      int_en = 1; @(negedge clk);
      #1 cmp("R6 intr taken when enabled", int'(int_req), 1);
      cmp("R6 source is not nmi", int'(int_nmi), 0);
      intr = 0; cyc(4);
      #1 cmp("R7 request held without ack", int'(int_req), 1);
      int_ack = 1; @(negedge clk); int_ack = 0;
      #1 cmp("R7 request dropped after ack", int'(int_req), 0);
      cyc(1); iret = 1; @(negedge clk); iret = 0;
      #1 cmp("R7 return to running", int'(fetch_en), 1);

      // R4 R5 R6: wait with interrupt
      issue(3'd2, 1, 6'd0, 0);
      #1 cmp("R10 no lock in wait", int'(bus_lock), 0);
      cyc(3);
      nmi = 1; intr = 1; @(negedge clk); nmi = 0; intr = 0;
      #1 cmp("R6 nmi wins", int'(int_nmi), 1);
      cmp("R5 return target is wait", int'(ret_to_wait), 1);
      service();
      #1 cmp("R5 back in wait after return", int'(fetch_en), 0);
      cyc(2);
      test_n = 0; @(negedge clk);
      #1 cmp("R4 synchronizer latency", int'(instr_done), 0);
      @(negedge clk);
      #1 cmp("R4 wait ends on test", int'(instr_done), 1);
      @(negedge clk); test_n = 1;
      #1 cmp("R4 running after wait", int'(fetch_en), 1);
      cyc(3);

      // R12: test and interrupt in the same cycle
      issue(3'd2, 0, 6'd0, 0);
      cyc(3);
      test_n = 0; @(negedge clk); @(negedge clk); intr = 1;
      #1 cmp("R12 wait ends first", int'(instr_done), 1);
      cmp("R12 no request yet", int'(int_req), 0);
      @(negedge clk);
      #1 cmp("R12 interrupt blocks fetch", int'(fetch_en), 0);
      @(negedge clk); intr = 0; test_n = 1;
      #1 cmp("R12 request from running", int'(int_req), 1);
      cmp("R12 return target running", int'(ret_to_wait), 0);
      service();
      #1 cmp("R12 running after service", int'(fetch_en), 1);

      // R1: reset overrides halt, wait and a locked instruction
      issue(3'd1, 0, 6'd0, 0);
      cyc(2); rst = 1; @(negedge clk); rst = 0;
      #1 cmp("R1 reset leaves halt", int'(fetch_en), 1);
      cyc(2);
      issue(3'd2, 0, 6'd0, 0);
      cyc(2); rst = 1; @(negedge clk); rst = 0;
      #1 cmp("R1 reset leaves wait", int'(fetch_en), 1);
      cyc(2);
      issue(3'd0, 1, 6'd0, 0);
      rst = 1; @(negedge clk); rst = 0;
      #1 cmp("R1 reset clears lock", int'(bus_lock), 0);
      cmp("R1 running after reset", int'(fetch_en), 1);
      cyc(3);
      run_end = 1;
   end

   initial begin
      wait (run_end || wd_hit);
      #1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule